// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Channel Bank

This block holds five pulse-width channels. Each one owns a down-counter and an active compare register, both fed from a pair of buffer registers that software writes through a single-beat register-write port. One shared 32-bit control word carries, for every channel, a run bit, a load-now bit, an output-polarity bit and a repeat bit. The channel position inside that word is irregular: one 4-bit slot is skipped after channel 0, and the last channel has a shortened 3-bit slot.

A channel advances only on cycles where its tick enable is high; the tick comes from a divider outside this block. A buffered count of N gives a period of N + 1 ticks. The raw wave is low while the counter is above the active compare value and high from the match down to zero. A compare of all ones never matches, which gives a steady level for the whole period. The polarity bit XORs the raw wave onto the pin. Buffer writes reach the active registers only at a reload or while the load-now bit is set, so software can prepare a new period and duty without a glitch.

Top module: `dbpwm_top`

## Requirements
- R1: After a synchronous active-low reset, the control word, every buffer and every active counter and compare register are zero, and every `pwm_out` bit is low.
- R2: Channel c uses control slot s = 0 for c = 0 and s = c + 1 otherwise, at bits 4s..4s+3: +0 run, +1 load-now, +2 invert, +3 repeat. So channel 0 uses bits 0..3, channel 1 bits 8..11, channel 2 bits 12..15 and channel 3 bits 16..19. Bits 7:4 have no effect on any output.
- R3: The last channel (channel 4) uses slot 5 with three bits: bit 20 run, bit 21 load-now, bit 22 repeat. It has no invert, so its pin always carries its raw wave. Bit 23 has no effect.
- R4: A write to byte offset 0x08 loads the whole control word. A write to 0x0C + 0x0C·c loads the count buffer of channel c, and a write to 0x10 + 0x0C·c loads its compare buffer. Both buffers take the low CW bits of the write data.
- R5: On every clock edge at which a channel's load-now bit is set, its active counter and compare register are loaded from its buffers, its counter does not step, and a stopped state is cleared.
- R6: With run set and load-now clear, the counter steps down by one on each tick. The raw wave is high while counter ≤ active compare and low otherwise. A buffered count N and compare C therefore give a period of N + 1 ticks with C + 1 high ticks.
- R7: When the counter is zero and a tick arrives with repeat set, the counter and compare registers reload from the buffers.
- R8: When the counter is zero and a tick arrives with repeat clear, the channel stops: its counter holds and its raw wave stays low until a load-now or until run is cleared.
- R9: An active compare of all ones never matches, so the raw wave stays low for the whole period, across reloads.
- R10: The pin is the raw wave XOR the invert bit. With invert set, the pin is high for N − C ticks per period.
- R11: The counter holds on cycles without a tick and whenever run is clear. While run is clear, the raw wave is low.
- R12: A buffer write does not change the running period or duty. The new values take effect at the next reload or load-now.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (8) | Byte offset of the register written |
| wr_data | input | 32 | Write data |
| tick | input | NUM_CH (5) | Per-channel count enable from the divider |
| pwm_out | output | NUM_CH (5) | Per-channel PWM pin |

## Verification
A write sampled at edge k is visible in the registers just after edge k. A load-now bit written at edge k loads the active registers at edge k + 1, so writing the run word at k + 1 leaves the channel at its full count right after that edge. The pins are decoded combinationally from the active registers, so each pin value belongs to the state after the most recent edge. The bench queues one expected pin value per cycle, starting with the state after the edge that captured the last stimulus. It compares each value at the following falling edge, so every step, reload, stop and hold is checked in the exact cycle it is due.

// File: rtl/dbpwm_pkg.sv
// Package: shared constants and control-word slot arithmetic for the
// PWM channel bank. Assumes at most seven channels so every slot fits
// inside the 32-bit control word.
package dbpwm_pkg;

    localparam int CTRL_W      = 32;
    localparam int CTRL_OFS    = 8;     // byte offset of the control word
    localparam int CNT_OFS     = 12;    // count buffer of channel 0
    localparam int CMP_OFS     = 16;    // compare buffer of channel 0
    localparam int CH_STRIDE   = 12;    // byte distance between channels

    localparam int BIT_RUN     = 0;
    localparam int BIT_LOAD    = 1;
    localparam int BIT_INV     = 2;
    localparam int BIT_REPEAT  = 3;
    localparam int BIT_REP_END = 2;     // repeat position in the short slot

    // Lowest control bit of channel c: slot 1 is skipped after channel 0.
    function automatic int slot_base(input int c);
        return (c == 0) ? 0 : 4 * (c + 1);
    endfunction

endpackage

// File: rtl/dbpwm_regs.sv
// Register file: holds the control word and every channel's count and
// compare buffers. Writes are single-cycle and take effect at the edge
// that samples wr_en. Assumes the address map fits in AW bits.
module dbpwm_regs
    import dbpwm_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int CW     = 16,
    parameter int AW     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [AW-1:0]                wr_addr,
    input  logic [CTRL_W-1:0]            wr_data,
    output logic [CTRL_W-1:0]            ctrl_q,
    output logic [NUM_CH-1:0][CW-1:0]    cnt_buf,
    output logic [NUM_CH-1:0][CW-1:0]    cmp_buf
);

    localparam logic [AW-1:0] A_CTRL = AW'(CTRL_OFS);

    // Control word register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en && wr_addr == A_CTRL)
            ctrl_q <= wr_data;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_buf
        localparam logic [AW-1:0] A_CNT = AW'(CNT_OFS + CH_STRIDE * c);
        localparam logic [AW-1:0] A_CMP = AW'(CMP_OFS + CH_STRIDE * c);

        // Count and compare buffers of one channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_buf[c] <= '0;
                cmp_buf[c] <= '0;
            end else if (wr_en) begin
                if (wr_addr == A_CNT)
                    cnt_buf[c] <= wr_data[CW-1:0];
                if (wr_addr == A_CMP)
                    cmp_buf[c] <= wr_data[CW-1:0];
            end
        end
    end

endmodule

// File: rtl/dbpwm_ctrl_map.sv
// Control decoder: picks each channel's run, load-now, invert and
// repeat bits out of the shared word. The last channel has a short
// slot with repeat in the invert position and no invert at all.
module dbpwm_ctrl_map
    import dbpwm_pkg::*;
#(
    parameter int NUM_CH = 5
) (
    input  logic [CTRL_W-1:0] ctrl_q,
    output logic [NUM_CH-1:0] run,
    output logic [NUM_CH-1:0] load,
    output logic [NUM_CH-1:0] inv,
    output logic [NUM_CH-1:0] rep
);

    logic unused_ctrl;
    assign unused_ctrl = ^ctrl_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_map
        localparam int B = slot_base(c);
        assign run[c]  = ctrl_q[B + BIT_RUN];
        assign load[c] = ctrl_q[B + BIT_LOAD];
        if (c == NUM_CH - 1) begin : g_short
            assign inv[c] = 1'b0;
            assign rep[c] = ctrl_q[B + BIT_REP_END];
        end else begin : g_full
            assign inv[c] = ctrl_q[B + BIT_INV];
            assign rep[c] = ctrl_q[B + BIT_REPEAT];
        end
    end

endmodule

// File: rtl/dbpwm_chan.sv
// One PWM channel: an active down-counter and compare register loaded
// from the buffers by load-now or by a repeat reload. Steps only on
// tick while running. Raw wave is high while count <= compare, never for
// an all-ones compare. The pin is decoded combinationally from state.
module dbpwm_chan #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          run,
    input  logic          load,
    input  logic          inv,
    input  logic          rep,
    input  logic [CW-1:0] cnt_buf,
    input  logic [CW-1:0] cmp_buf,
    output logic [CW-1:0] act_cnt,
    output logic [CW-1:0] act_cmp,
    output logic          stopped,
    output logic          raw,
    output logic          pin
);

    localparam logic [CW-1:0] NEVER = '1;

    // Counter, compare and stop state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_cnt <= '0;
            act_cmp <= '0;
            stopped <= 1'b0;
        end else if (load) begin
            act_cnt <= cnt_buf;
            act_cmp <= cmp_buf;
            stopped <= 1'b0;
        end else if (!run) begin
            stopped <= 1'b0;
        end else if (tick && !stopped) begin
            if (act_cnt == '0) begin
                if (rep) begin
                    act_cnt <= cnt_buf;
                    act_cmp <= cmp_buf;
                end else begin
                    stopped <= 1'b1;
                end
            end else begin
                act_cnt <= act_cnt - 1'b1;
            end
        end
    end

    // Raw wave and polarity.
    always_comb begin
        raw = run && !stopped && (act_cmp != NEVER) && (act_cnt <= act_cmp);
        pin = raw ^ inv;
    end

endmodule

// File: rtl/dbpwm_top.sv
// Top of the PWM channel bank: register file, control decoder and one
// channel instance per output. Ticks come from an external divider.
module dbpwm_top
    import dbpwm_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int CW     = 16,
    parameter int AW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic [NUM_CH-1:0] tick,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [CTRL_W-1:0]         ctrl_q;
    logic [NUM_CH-1:0][CW-1:0] cnt_buf;
    logic [NUM_CH-1:0][CW-1:0] cmp_buf;
    logic [NUM_CH-1:0][CW-1:0] act_cnt;
    logic [NUM_CH-1:0][CW-1:0] act_cmp;
    logic [NUM_CH-1:0]         run, load, inv, rep, stopped, raw;

    dbpwm_regs #(.NUM_CH(NUM_CH), .CW(CW), .AW(AW)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .cnt_buf (cnt_buf),
        .cmp_buf (cmp_buf)
    );

    dbpwm_ctrl_map #(.NUM_CH(NUM_CH)) map_i (
        .ctrl_q (ctrl_q),
        .run    (run),
        .load   (load),
        .inv    (inv),
        .rep    (rep)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dbpwm_chan #(.CW(CW)) chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick[c]),
            .run     (run[c]),
            .load    (load[c]),
            .inv     (inv[c]),
            .rep     (rep[c]),
            .cnt_buf (cnt_buf[c]),
            .cmp_buf (cmp_buf[c]),
            .act_cnt (act_cnt[c]),
            .act_cmp (act_cmp[c]),
            .stopped (stopped[c]),
            .raw     (raw[c]),
            .pin     (pwm_out[c])
        );
    end

endmodule

// File: rtl/dbpwm_chk.sv
// Checker: per-channel timing properties of the PWM bank, bound into
// the top so it sees the decoded control bits and channel state.
module dbpwm_chk #(
    parameter int NUM_CH = 5,
    parameter int CW     = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH-1:0]         tick,
    input  logic [NUM_CH-1:0]         run,
    input  logic [NUM_CH-1:0]         load,
    input  logic [NUM_CH-1:0]         rep,
    input  logic [NUM_CH-1:0]         stopped,
    input  logic [NUM_CH-1:0]         raw,
    input  logic [NUM_CH-1:0][CW-1:0] cnt_buf,
    input  logic [NUM_CH-1:0][CW-1:0] act_cnt,
    input  logic [NUM_CH-1:0][CW-1:0] act_cmp
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_p
        // R5: load-now copies the count buffer into the counter.
        p_load_copies_r5: assert property (@(posedge clk) disable iff (!rst_n)
            load[c] |=> act_cnt[c] == $past(cnt_buf[c]));

        // R11: no tick or no run means the counter holds.
        p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (!load[c] && (!tick[c] || !run[c])) |=> $stable(act_cnt[c]));

        // R6: a tick on a running, nonzero counter steps it down by one.
        p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (run[c] && tick[c] && !load[c] && !stopped[c] && act_cnt[c] != '0)
            |=> act_cnt[c] == $past(act_cnt[c]) - 1'b1);

        // R7: terminal count with repeat reloads from the buffer.
        p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (run[c] && tick[c] && !load[c] && !stopped[c] && rep[c] && act_cnt[c] == '0)
            |=> act_cnt[c] == $past(cnt_buf[c]));

        // R8: a stopped running channel stays stopped with the counter held.
        p_stays_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (stopped[c] && run[c] && !load[c]) |=> (stopped[c] && $stable(act_cnt[c])));

        // R9: an all-ones compare never yields a high raw wave.
        p_full_duty_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (act_cmp[c] == '1) |-> !raw[c]);
    end

endmodule

bind dbpwm_top dbpwm_chk #(.NUM_CH(NUM_CH), .CW(CW)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .run     (run),
    .load    (load),
    .rep     (rep),
    .stopped (stopped),
    .raw     (raw),
    .cnt_buf (cnt_buf),
    .act_cnt (act_cnt),
    .act_cmp (act_cmp)
);

// File: tb/dbpwm_top_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks program the bank and push one expected
// pin item per cycle; a monitor pops and compares at each falling edge.
module dbpwm_top_tb_top;

    localparam int NCH = 5;
    localparam int CW  = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [7:0]     wr_addr = '0;
    logic [31:0]    wr_data = '0;
    logic [NCH-1:0] tick = '1;
    logic [NCH-1:0] pwm_out;

    typedef struct {
        logic [NCH-1:0] val;
        logic [NCH-1:0] msk;
        string          tag;
    } item_t;

    item_t          exp_q[$];
    logic [NCH-1:0] pv [64];
    logic [NCH-1:0] pm [64];
    int             n_chk = 0;
    int             n_bad = 0;
    bit             done = 1'b0;

    always #4 clk = ~clk;

    dbpwm_top dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tick    (tick),
        .pwm_out (pwm_out)
    );

    // Monitor: pop one expected item per falling edge and compare.
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            item_t it;
            it = exp_q.pop_front();
            n_chk++;
            if ((pwm_out & it.msk) !== (it.val & it.msk)) begin
                n_bad++;
                $display("FAIL %s: pwm_out=%b expected=%b (mask %b) at %0t",
                         it.tag, pwm_out, it.val, it.msk, $time);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic clear_plan();
        for (int i = 0; i < 64; i++) begin
            pv[i] = '0;
            pm[i] = '0;
        end
    endtask

    // Expected pin sequence of channel c from the requirement formulas.
    task automatic plan_ch(input int c, input int n, input int cnt0, input int ccur,
                           input int nnext, input int cnext, input bit inv, input bit rep);
        int cnt;
        int cc;
        bit stp;
        bit r;
        cnt = cnt0; cc = ccur; stp = 1'b0;
        for (int i = 0; i < n; i++) begin
            r = !stp && (cc != 32'hFFFF) && (cnt <= cc);
            pv[i][c] = r ^ inv;
            pm[i][c] = 1'b1;
            if (!stp) begin
                if (cnt == 0) begin
                    if (rep) begin cnt = nnext; cc = cnext; end
                    else stp = 1'b1;
                end else begin
                    cnt = cnt - 1;
                end
            end
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic commit(input int n, input string tag);
        for (int i = 0; i < n; i++) exp_q.push_back('{pv[i], pm[i], tag});
        clear_plan();
        drain();
    endtask

    task automatic push_const(input logic [NCH-1:0] m, input logic [NCH-1:0] v,
                              input int n, input string tag);
        for (int i = 0; i < n; i++) exp_q.push_back('{v, m, tag});
        drain();
    endtask

    function automatic logic [7:0] a_cnt(input int c);
        return 8'(12 + 12 * c);
    endfunction
    function automatic logic [7:0] a_cmp(input int c);
        return 8'(16 + 12 * c);
    endfunction

    // Two control writes: load-now word, then run word one edge later.
    task automatic launch(input logic [31:0] w_load, input logic [31:0] w_run);
        wr(8'h08, w_load);
        wr(8'h08, w_run);
    endtask

    // Watchdog.
    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        clear_plan();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset leaves every pin low.
        push_const('1, '0, 3, "R1 reset");

        // R6 R7 R4 R2: channel 0, N=5 C=2, bits 7:4 set as well.
        wr(a_cnt(0), 5); wr(a_cmp(0), 2);
        launch(32'h0000_0002, 32'h0000_00F9);
        plan_ch(0, 12, 5, 2, 5, 2, 1'b0, 1'b1);
        commit(12, "R6 R7 R2 ch0 period");

        // R10: same with invert, high N-C ticks.
        launch(32'h0000_0002, 32'h0000_000D);
        plan_ch(0, 12, 5, 2, 5, 2, 1'b1, 1'b1);
        commit(12, "R10 ch0 inverted");

        // R2 R4: channel 1 in slot 2 (bits 8..11).
        wr(8'h08, 32'h0);
        wr(a_cnt(1), 3); wr(a_cmp(1), 0);
        launch(32'h0000_0200, 32'h0000_0900);
        plan_ch(1, 8, 3, 0, 3, 0, 1'b0, 1'b1);
        commit(8, "R2 ch1 slot");

        // R2: channels 2 and 3 together, ch2 inverted.
        wr(8'h08, 32'h0);
        wr(a_cnt(2), 4); wr(a_cmp(2), 1);
        wr(a_cnt(3), 6); wr(a_cmp(3), 3);
        launch(32'h0002_2000, 32'h0009_D000);
        plan_ch(2, 14, 4, 1, 4, 1, 1'b1, 1'b1);
        plan_ch(3, 14, 6, 3, 6, 3, 1'b0, 1'b1);
        commit(14, "R2 ch2 ch3 slots");

        // R3: last channel, repeat at bit 22, bit 23 no invert.
        wr(8'h08, 32'h0);
        wr(a_cnt(4), 2); wr(a_cmp(4), 1);
        launch(32'h0020_0000, 32'h00D0_0000);
        plan_ch(4, 9, 2, 1, 2, 1, 1'b0, 1'b1);
        commit(9, "R3 ch4 repeat bit 22");

        // R3 R8: last channel with only bit 23 set stops after one period.
        launch(32'h0020_0000, 32'h0090_0000);
        plan_ch(4, 8, 2, 1, 2, 1, 1'b0, 1'b0);
        commit(8, "R3 R8 ch4 bit 23 inert");

        // R8: clear repeat mid-period on channel 0.
        wr(8'h08, 32'h0);
        wr(a_cnt(0), 5); wr(a_cmp(0), 2);
        launch(32'h0000_0002, 32'h0000_0009);
        wr(8'h08, 32'h0000_0001);
        plan_ch(0, 10, 4, 2, 5, 2, 1'b0, 1'b0);
        commit(10, "R8 stop after period");

        // R12: buffer writes wait for the reload.
        launch(32'h0000_0002, 32'h0000_0009);
        wr(a_cnt(0), 2);
        wr(a_cmp(0), 0);
        plan_ch(0, 10, 3, 2, 2, 0, 1'b0, 1'b1);
        commit(10, "R12 buffered update");

        // R5: load-now held keeps the counter at the buffer value.
        wr(a_cnt(0), 4); wr(a_cmp(0), 3);
        wr(8'h08, 32'h0000_000B);
        @(posedge clk); #1;
        push_const(5'b00001, 5'b00000, 4, "R5 load-now holds");
        wr(8'h08, 32'h0000_0009);
        plan_ch(0, 10, 4, 3, 4, 3, 1'b0, 1'b1);
        commit(10, "R5 restart after load-now");

        // R9 R10: all-ones compare, inverted pin high throughout.
        wr(a_cnt(0), 3); wr(a_cmp(0), 32'h0000_FFFF);
        launch(32'h0000_0002, 32'h0000_000D);
        push_const(5'b00001, 5'b00001, 10, "R9 full duty");

        // R11: ticks withheld freeze the channel mid-high.
        wr(a_cnt(0), 3); wr(a_cmp(0), 1);
        launch(32'h0000_0002, 32'h0000_0009);
        @(posedge clk); @(posedge clk); #1;
        tick[0] = 1'b0;
        push_const(5'b00001, 5'b00001, 6, "R11 no tick hold");
        @(posedge clk); #1;
        tick[0] = 1'b1;
        plan_ch(0, 8, 1, 1, 3, 1, 1'b0, 1'b1);
        commit(8, "R11 resume on tick");

        // R11: run cleared drives the raw wave low.
        wr(8'h08, 32'h0);
        push_const(5'b00001, 5'b00000, 5, "R11 run low");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule